// File: doc/BRIEF.md
# Flip-and-Patch Activation Datapath

This block sits between a low-voltage activation store and a processing-element array. It corrects activations whose storage cells have permanent faults. Each word address carries two tags. A flip tag makes the word live in the store bit-reversed, so that faulty high-order cells end up holding low-order bits. A patch tag makes the word's correct value come from a small, fully associative patching cache.

On a write, each flip-tagged word is stored reversed. Each patch-tagged word also refreshes its cache entry. On a block read, the raw block and its tags are captured in holding registers. Patch-tagged words are then looked up in the cache, one per cycle. Every word is rebuilt through a four-way word selector: raw, reversed, patched, or zero on a cache miss. The assembled block is released as one four-word output.

Tags and cache entries are loaded through a configuration port before operation, one set per supply-voltage level. The port only acts while the block is idle.

Top module: `fp_act_datapath`

## Requirements
- R1: After reset, busy, out_valid and out_err are low, every flip and patch tag is clear, and every patching-cache entry is invalid.
- R2: On an accepted write, word lane i occupies wr_data bits [8i+7:8i] and has word address wr_blk*4+i. A word whose flip tag is set at write time is stored with bit j moved to bit 7-j. Other words are stored as given.
- R3: On a read, a word with both tags clear returns the stored word unchanged. A word with only the flip tag set returns the stored word bit-reversed, so a value written and read under the same flip tag comes back unchanged.
- R4: A word whose patch tag is set returns the value of the cache entry whose address equals its word address, whatever its flip tag.
- R5: The cache is fully associative. Any valid entry can serve any word address, and when several valid entries match, the one with the lowest index serves.
- R6: A patch-tagged word with no matching valid entry reads as zero, and out_err is high together with out_valid. out_err is low in every other cycle.
- R7: With P patch-tagged words in the block, out_valid is high for exactly one cycle, at the (P+1)-th rising edge after the edge that accepted the read. busy is high from the accepting edge until that edge. out_data holds its value until the next completed read.
- R8: An accepted write of a patch-tagged word overwrites the value of the matching valid cache entry. A write never creates, moves or invalidates an entry.
- R9: Configuration writes, block writes and read requests have no effect while busy is high. A read request in the same cycle as a write request is ignored, and the write is performed.
- R10: A tag configuration write sets both tags of one word address (flip and patch bits). A cache configuration write loads the entry at cfg_pc_idx with its valid bit, word address and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tag_we | input | 1 | Tag configuration write strobe |
| cfg_tag_addr | input | 8 | Word address of the tag write |
| cfg_tag_flip | input | 1 | Flip tag value |
| cfg_tag_patch | input | 1 | Patch tag value |
| cfg_pc_we | input | 1 | Cache entry configuration write strobe |
| cfg_pc_idx | input | 3 | Cache entry index |
| cfg_pc_valid | input | 1 | Entry valid bit |
| cfg_pc_addr | input | 8 | Entry word address |
| cfg_pc_data | input | 8 | Entry fault-free value |
| wr_en | input | 1 | Block write request |
| wr_blk | input | 6 | Block address of the write |
| wr_data | input | 32 | Four words to write, lane 0 in the low byte |
| rd_en | input | 1 | Block read request |
| rd_blk | input | 6 | Block address of the read |
| busy | output | 1 | A read is in progress |
| out_valid | output | 1 | One-cycle strobe: out_data holds a finished block |
| out_data | output | 32 | Rebuilt block, lane 0 in the low byte |
| out_err | output | 1 | A patch-tagged word in the block missed the cache |

## Verification
Blocks are read under mixed tag patterns: no tags, flip only, both tags on one word, several patched words per block, and patched words that miss. Each pattern isolates one selector path, and the observed latency shows the stall count tracking the number of patched words. A block is written flip-tagged and then read with its tags cleared, which exposes the reversed storage that a round trip would hide. A cache entry at the highest index serves a word with no write, which separates associativity from write-side refresh. A tag write issued while a patched read is draining is followed by a read of the targeted block, which shows that the write was dropped.

// File: rtl/fp_pkg.sv
package fp_pkg;

  // Word selector choices, one per output lane
  typedef enum logic [1:0] {
    SEL_RAW   = 2'd0,
    SEL_FLIP  = 2'd1,
    SEL_PATCH = 2'd2,
    SEL_ZERO  = 2'd3
  } wsel_e;

  // Patch outranks flip; a patch miss falls to the zero input
  function automatic wsel_e pick_sel(input logic patch, input logic flip, input logic hit);
    if (patch) return hit ? SEL_PATCH : SEL_ZERO;
    if (flip)  return SEL_FLIP;
    return SEL_RAW;
  endfunction

endpackage

// File: rtl/fp_word_sel.sv
module fp_word_sel #(
  parameter int unsigned W = 8
) (
  input  fp_pkg::wsel_e  sel,
  input  logic [W-1:0]   raw,
  input  logic [W-1:0]   patched,
  output logic [W-1:0]   dout
);

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < int'(W); i++) r[i] = v[int'(W)-1-i];
    return r;
  endfunction

  always_comb begin
    unique case (sel)
      fp_pkg::SEL_RAW:   dout = raw;
      fp_pkg::SEL_FLIP:  dout = bit_rev(raw);
      fp_pkg::SEL_PATCH: dout = patched;
      default:           dout = '0;
    endcase
  end

endmodule

// File: rtl/fp_patch_cache.sv
module fp_patch_cache #(
  parameter  int unsigned ENTRIES = 8,
  parameter  int unsigned AW      = 8,
  parameter  int unsigned W       = 8,
  parameter  int unsigned LANES   = 4,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic                       cfg_valid,
  input  logic [AW-1:0]              cfg_addr,
  input  logic [W-1:0]               cfg_data,
  input  logic [LANES-1:0]           upd_en,
  input  logic [LANES-1:0][AW-1:0]   upd_addr,
  input  logic [LANES-1:0][W-1:0]    upd_data,
  input  logic [AW-1:0]              lk_addr,
  output logic                       lk_hit,
  output logic [W-1:0]               lk_data
);

  logic [ENTRIES-1:0]         valid_q;
  logic [ENTRIES-1:0][AW-1:0] addr_q;
  logic [ENTRIES-1:0][W-1:0]  data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      for (int e = 0; e < int'(ENTRIES); e++) begin
        if (cfg_we && cfg_idx == IDX_W'(e)) begin
          valid_q[e] <= cfg_valid;
          addr_q[e]  <= cfg_addr;
          data_q[e]  <= cfg_data;
        end else begin
          for (int l = 0; l < int'(LANES); l++)
            if (upd_en[l] && valid_q[e] && addr_q[e] == upd_addr[l])
              data_q[e] <= upd_data[l];
        end
      end
    end
  end

  // Lowest matching index wins
  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int e = int'(ENTRIES) - 1; e >= 0; e--) begin
      if (valid_q[e] && addr_q[e] == lk_addr) begin
        lk_hit  = 1'b1;
        lk_data = data_q[e];
      end
    end
  end

  // R8: write-side refresh never changes the population of valid entries
  p_no_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $countones(valid_q) == $countones($past(valid_q)));

endmodule

// File: rtl/fp_fetch_seq.sv
module fp_fetch_seq #(
  parameter  int unsigned LANES  = 4,
  localparam int unsigned LIDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LANES-1:0]  mask,
  output logic              busy,
  output logic              fetch_fire,
  output logic [LIDX_W-1:0] fetch_lane,
  output logic              done
);

  logic [LANES-1:0] pend_q;
  logic             busy_q;

  always_comb begin
    fetch_lane = '0;
    for (int i = int'(LANES) - 1; i >= 0; i--)
      if (pend_q[i]) fetch_lane = LIDX_W'(i);
  end

  assign fetch_fire = busy_q &  (|pend_q);
  assign done       = busy_q & ~(|pend_q);
  assign busy       = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      pend_q <= mask;
    end else if (fetch_fire) begin
      pend_q[fetch_lane] <= 1'b0;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  // R7: one patched word is served per stall cycle
  p_one_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && busy_q) |-> $countones(pend_q) + 1 == $countones($past(pend_q)));

endmodule

// File: rtl/fp_act_datapath.sv
module fp_act_datapath #(
  parameter  int unsigned WORD_W     = 8,
  parameter  int unsigned LANES      = 4,
  parameter  int unsigned BLK_AW     = 6,
  parameter  int unsigned PC_ENTRIES = 8,
  localparam int unsigned LANE_AW    = $clog2(LANES),
  localparam int unsigned WADDR_W    = BLK_AW + LANE_AW,
  localparam int unsigned BLK_W      = WORD_W * LANES,
  localparam int unsigned BLOCKS     = 1 << BLK_AW,
  localparam int unsigned WORDS      = 1 << WADDR_W,
  localparam int unsigned PC_IDX_W   = $clog2(PC_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_tag_we,
  input  logic [WADDR_W-1:0]  cfg_tag_addr,
  input  logic                cfg_tag_flip,
  input  logic                cfg_tag_patch,
  input  logic                cfg_pc_we,
  input  logic [PC_IDX_W-1:0] cfg_pc_idx,
  input  logic                cfg_pc_valid,
  input  logic [WADDR_W-1:0]  cfg_pc_addr,
  input  logic [WORD_W-1:0]   cfg_pc_data,
  input  logic                wr_en,
  input  logic [BLK_AW-1:0]   wr_blk,
  input  logic [BLK_W-1:0]    wr_data,
  input  logic                rd_en,
  input  logic [BLK_AW-1:0]   rd_blk,
  output logic                busy,
  output logic                out_valid,
  output logic [BLK_W-1:0]    out_data,
  output logic                out_err
);

  logic idle, wr_go, rd_go;
  logic fetch_fire, done;
  logic [LANE_AW-1:0] fetch_lane;

  assign idle  = ~busy;
  assign wr_go = wr_en & idle;
  assign rd_go = rd_en & idle & ~wr_en;

  // ---------------- fault-map tags ----------------
  logic [WORDS-1:0] flip_mem, patch_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_mem  <= '0;
      patch_mem <= '0;
    end else if (cfg_tag_we && idle) begin
      flip_mem[cfg_tag_addr]  <= cfg_tag_flip;
      patch_mem[cfg_tag_addr] <= cfg_tag_patch;
    end
  end

  // ---------------- activation store ----------------
  logic [BLK_W-1:0] mem_q [BLOCKS];
  logic [BLK_W-1:0] wr_store;

  logic [LANES-1:0]              upd_en;
  logic [LANES-1:0][WADDR_W-1:0] upd_addr;
  logic [LANES-1:0][WORD_W-1:0]  upd_data;
  logic [LANES-1:0]              rd_fmask, rd_pmask;
  fp_pkg::wsel_e                 wsel [LANES];

  for (genvar l = 0; l < int'(LANES); l++) begin : g_wlane
    logic [WADDR_W-1:0] wa, ra;
    assign wa = {wr_blk, LANE_AW'(l)};
    assign ra = {rd_blk, LANE_AW'(l)};
    assign wsel[l]     = flip_mem[wa] ? fp_pkg::SEL_FLIP : fp_pkg::SEL_RAW;
    assign upd_en[l]   = wr_go & patch_mem[wa];
    assign upd_addr[l] = wa;
    assign upd_data[l] = wr_data[l*WORD_W +: WORD_W];
    assign rd_fmask[l] = flip_mem[ra];
    assign rd_pmask[l] = patch_mem[ra];

    fp_word_sel #(.W(WORD_W)) u_wenc (
      .sel     (wsel[l]),
      .raw     (wr_data[l*WORD_W +: WORD_W]),
      .patched ({WORD_W{1'b0}}),
      .dout    (wr_store[l*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem_q[wr_blk] <= wr_store;
  end

  // ---------------- patching cache ----------------
  logic                lk_hit;
  logic [WORD_W-1:0]   lk_data;
  logic [BLK_AW-1:0]   blk_q;

  fp_patch_cache #(
    .ENTRIES (PC_ENTRIES),
    .AW      (WADDR_W),
    .W       (WORD_W),
    .LANES   (LANES)
  ) u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_pc_we & idle),
    .cfg_idx   (cfg_pc_idx),
    .cfg_valid (cfg_pc_valid),
    .cfg_addr  (cfg_pc_addr),
    .cfg_data  (cfg_pc_data),
    .upd_en    (upd_en),
    .upd_addr  (upd_addr),
    .upd_data  (upd_data),
    .lk_addr   ({blk_q, fetch_lane}),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data)
  );

  fp_fetch_seq #(.LANES(LANES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rd_go),
    .mask       (rd_pmask),
    .busy       (busy),
    .fetch_fire (fetch_fire),
    .fetch_lane (fetch_lane),
    .done       (done)
  );

  // ---------------- holding registers ----------------
  logic [BLK_W-1:0]             raw_q;
  logic [LANES-1:0]             flip_q, patch_q, hit_q;
  logic [LANES-1:0][WORD_W-1:0] pv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      blk_q   <= '0;
      flip_q  <= '0;
      patch_q <= '0;
      hit_q   <= '0;
      pv_q    <= '0;
    end else if (rd_go) begin
      raw_q   <= mem_q[rd_blk];
      blk_q   <= rd_blk;
      flip_q  <= rd_fmask;
      patch_q <= rd_pmask;
      hit_q   <= '0;
    end else if (fetch_fire) begin
      pv_q[fetch_lane]  <= lk_data;
      hit_q[fetch_lane] <= lk_hit;
    end
  end

  // ---------------- block assembly ----------------
  logic [BLK_W-1:0] asm_data;
  fp_pkg::wsel_e    rsel [LANES];

  for (genvar l = 0; l < int'(LANES); l++) begin : g_rlane
    assign rsel[l] = fp_pkg::pick_sel(patch_q[l], flip_q[l], hit_q[l]);
    fp_word_sel #(.W(WORD_W)) u_rsel (
      .sel     (rsel[l]),
      .raw     (raw_q[l*WORD_W +: WORD_W]),
      .patched (pv_q[l]),
      .dout    (asm_data[l*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= done;
      out_err   <= done & (|(patch_q & ~hit_q));
      if (done) out_data <= asm_data;
    end
  end

  // ---------------- assertions ----------------
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> busy);

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_valid_after_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(busy) && !$past(fetch_fire)));

  p_err_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  p_cfg_blocked_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_tag_we) |=> ($stable(flip_mem) && $stable(patch_mem)));

endmodule

// File: tb/test_fp_act_datapath.sv
module test_fp_act_datapath;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tag_we = 0, cfg_tag_flip = 0, cfg_tag_patch = 0;
  logic [7:0]  cfg_tag_addr = '0;
  logic        cfg_pc_we = 0, cfg_pc_valid = 0;
  logic [2:0]  cfg_pc_idx = '0;
  logic [7:0]  cfg_pc_addr = '0, cfg_pc_data = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [5:0]  wr_blk = '0, rd_blk = '0;
  logic [31:0] wr_data = '0;
  logic        busy, out_valid, out_err;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fp_act_datapath i_fp_act_datapath (
    .clk, .rst_n, .cfg_tag_we, .cfg_tag_addr, .cfg_tag_flip, .cfg_tag_patch,
    .cfg_pc_we, .cfg_pc_idx, .cfg_pc_valid, .cfg_pc_addr, .cfg_pc_data,
    .wr_en, .wr_blk, .wr_data, .rd_en, .rd_blk,
    .busy, .out_valid, .out_data, .out_err
  );

  // ---------------- bench-side model ----------------
  logic [255:0] m_flip = '0, m_patch = '0;
  logic [31:0]  m_store [64];
  logic         m_pv [8];
  logic [7:0]   m_pa [8];
  logic [7:0]   m_pd [8];

  function automatic logic [7:0] mirror8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = v[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_tag(input int wa, input logic f, input logic p);
    @(negedge clk);
    cfg_tag_we = 1; cfg_tag_addr = 8'(wa); cfg_tag_flip = f; cfg_tag_patch = p;
    @(negedge clk);
    cfg_tag_we = 0;
    m_flip[wa] = f; m_patch[wa] = p;
  endtask

  task automatic set_entry(input int idx, input logic v, input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_pc_we = 1; cfg_pc_idx = 3'(idx); cfg_pc_valid = v; cfg_pc_addr = 8'(a); cfg_pc_data = d;
    @(negedge clk);
    cfg_pc_we = 0;
    m_pv[idx] = v; m_pa[idx] = 8'(a); m_pd[idx] = d;
  endtask

  task automatic write_blk(input int blk, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_blk = 6'(blk); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    for (int l = 0; l < 4; l++) begin
      int wa = blk * 4 + l;
      logic [7:0] w = d[l*8 +: 8];
      m_store[blk][l*8 +: 8] = m_flip[wa] ? mirror8(w) : w;
      if (m_patch[wa])
        for (int e = 0; e < 8; e++)
          if (m_pv[e] && m_pa[e] == 8'(wa)) m_pd[e] = w;
    end
  endtask

  task automatic expect_blk(input int blk, output logic [31:0] ed, output logic ee, output int elat);
    ee = 0; elat = 1;
    for (int l = 0; l < 4; l++) begin
      int wa = blk * 4 + l;
      logic [7:0] s = m_store[blk][l*8 +: 8];
      if (m_patch[wa]) begin
        logic hit = 0;
        logic [7:0] v = 8'h00;
        elat++;
        for (int e = 7; e >= 0; e--)
          if (m_pv[e] && m_pa[e] == 8'(wa)) begin hit = 1; v = m_pd[e]; end
        if (!hit) ee = 1;
        ed[l*8 +: 8] = v;
      end else begin
        ed[l*8 +: 8] = m_flip[wa] ? mirror8(s) : s;
      end
    end
  endtask

  task automatic start_read(input int blk);
    @(negedge clk);
    rd_en = 1; rd_blk = 6'(blk);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_done(output logic [31:0] d, output logic e, output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!out_valid && lat < 20);
    d = out_data; e = out_err;
  endtask

  task automatic read_check(input int blk, input string tag);
    logic [31:0] d, ed;
    logic e, ee;
    int lat, elat;
    expect_blk(blk, ed, ee, elat);
    start_read(blk);
    wait_done(d, e, lat);
    check({tag, " data"}, d, ed);
    check("R6 err flag", 32'(e), 32'(ee));
    check("R7 latency", 32'(lat), 32'(elat));
  endtask

  // {blk, data, flip lanes, patch lanes}
  localparam logic [47:0] VEC [8] = '{
    {8'd10, 32'h8142_17F0, 4'b0000, 4'b0001},
    {8'd11, 32'h0F3C_A501, 4'b1010, 4'b0010},
    {8'd12, 32'h1122_3344, 4'b0001, 4'b1100},
    {8'd13, 32'hC001_7E35, 4'b1111, 4'b0000},
    {8'd14, 32'h6D9B_2480, 4'b0100, 4'b0011},
    {8'd15, 32'hFACE_B00C, 4'b0000, 4'b1111},
    {8'd16, 32'h0123_4567, 4'b0000, 4'b0000},
    {8'd10, 32'h7700_AA55, 4'b0000, 4'b0001}
  };

  localparam int PC_ADDR [8] = '{40, 45, 50, 51, 55, 57, 62, 200};

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 64; b++) m_store[b] = '0;
    for (int e = 0; e < 8; e++) begin m_pv[e] = 0; m_pa[e] = '0; m_pd[e] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle reset state
    check("R1 busy", 32'(busy), 32'h0);
    check("R1 out_valid", 32'(out_valid), 32'h0);
    check("R1 out_err", 32'(out_err), 32'h0);

    // R1/R3: reset tags leave a block untouched
    write_blk(30, 32'hDEAD_BEEF);
    read_check(30, "R1 R3 untagged");

    // R10: load cache entries
    for (int e = 0; e < 8; e++) set_entry(e, 1'b1, PC_ADDR[e], 8'(8'h10 + 8'(e) * 8'h13));

    // table walk: R3 R4 R6 R7 R8
    for (int v = 0; v < 8; v++) begin
      int blk = int'(VEC[v][47:40]);
      for (int l = 0; l < 4; l++) set_tag(blk * 4 + l, VEC[v][4 + l], VEC[v][l]);
      write_blk(blk, VEC[v][39:8]);
      read_check(blk, "R3 R4 R8 vector");
    end

    // R2: stored word is bit-reversed, seen once the flip tags are cleared
    for (int l = 0; l < 4; l++) set_tag(80 + l, 1'b1, 1'b0);
    write_blk(20, 32'h0102_80C3);
    for (int l = 0; l < 4; l++) set_tag(80 + l, 1'b0, 1'b0);
    begin
      logic [31:0] d; logic e; int lat;
      start_read(20);
      wait_done(d, e, lat);
      check("R2 stored reversed", d, 32'h8040_01C3);
    end

    // R5: highest-index entry serves an untouched word
    write_blk(50, 32'h3344_5566);
    set_tag(200, 1'b1, 1'b1);
    read_check(50, "R5 assoc");

    // R9: tag write while draining a patched read is dropped
    begin
      logic [31:0] d, ed; logic e, ee; int lat, elat;
      expect_blk(14, ed, ee, elat);
      @(negedge clk);
      rd_en = 1; rd_blk = 6'd14;
      @(negedge clk);
      rd_en = 0;
      cfg_tag_we = 1; cfg_tag_addr = 8'd64; cfg_tag_flip = 1; cfg_tag_patch = 0;
      @(negedge clk);
      cfg_tag_we = 0;
      lat = 1;
      while (!out_valid && lat < 20) begin @(negedge clk); lat++; end
      d = out_data;
      check("R9 busy read data", d, ed);
      check("R7 busy read latency", 32'(lat), 32'(elat));
      @(negedge clk);
      check("R7 one-cycle valid", 32'(out_valid), 32'h0);
      check("R7 data held", out_data, ed);
    end
    read_check(16, "R9 tag unchanged");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule